// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Drive Sequencer

This block turns latched display bits and a handful of mode controls into drive-level codes for the common and segment pins of a multiplexed LCD. A tick input paces the frame. Each common is selected in turn, one per time slot. Every frame is split into two halves, and the drive inverts in the second half so that no pixel carries a DC component. Every output pin carries a 2-bit code, and a downstream analog buffer stage turns the code into one of four voltages.

The multiplex ratio can be changed at run time between three and four commons. The bias scheme can be changed at run time between half and third bias. In three-common operation the fourth common pin becomes an extra segment. A count input hands the lowest-numbered segment pins over to static general-purpose output use. Three conditions override the waveforms: a blanking control that forces every segment to its off level, a power-saving control that stops the waveforms and grounds the drive pins, and an active-low inhibit that grounds everything and takes the ports back.

Top module: `lcd_mux_drive`

## Requirements
- R1: While reset is asserted, and on the first sample after it, every level code is 0 and no port is enabled. Reset is synchronous and active low.
- R2: Slot s (0-based) selects common s. A slot lasts SLOT_TICKS ticks when fast_frame is 1 and 2*SLOT_TICKS ticks when it is 0. The frame runs slot 0 up to the last common in the first half, then the same order again in the second half, and then it wraps. Outputs reflect a tick or an input change one clock after it is sampled.
- R3: The level codes are 0 = ground, 1 = one third, 2 = the middle level (one half with half bias, two thirds with third bias), and 3 = full. A selected common drives 3 in the first half and 0 in the second half. With third bias an unselected common drives 1 in the first half and 2 in the second half. With half bias an unselected common drives 2 in both halves.
- R4: Segment pin k takes its bit for slot s from seg_data[4*k+s]. A segment that is on drives 0 in the first half and 3 in the second half. A segment that is off drives 2 in the first half and 1 in the second half with third bias, and drives 2 in both halves with half bias. Pin k uses seg_lvl[2k+1:2k].
- R5: With duty4 = 0 there are three commons, and common pin 3 (com_lvl[7:6]) acts as a segment. It takes its bit for slot s from seg_data[4*N_SEG+s].
- R6: With blank = 1, every segment pin, including a common pin used as a segment, drives the off level. The commons are unaffected.
- R7: While save = 1, every common pin and every non-port segment pin drives 0, and port pins keep their static level. When save is released, the frame restarts at slot 0 in the first half.
- R8: While inhibit_n = 0, every level code and every port_en bit is 0. The frame timing keeps counting ticks.
- R9: When port_cnt = n, pins 0 up to min(n, N_PORT)-1 become ports (port_en[k] = 1). A port pin drives 3 if seg_data[4*k] is set and 0 otherwise, whatever the slot or phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle frame timing pulse |
| duty4 | input | 1 | 1 = four commons, 0 = three commons |
| half_bias | input | 1 | 1 = half bias, 0 = third bias |
| fast_frame | input | 1 | 1 = short slot, 0 = double-length slot |
| blank | input | 1 | Force all segments to the off level |
| save | input | 1 | Power-saving: stop the waveforms |
| inhibit_n | input | 1 | Active-low display-off override |
| port_cnt | input | 4 | Number of low segment pins used as ports |
| seg_data | input | 4*N_SEG+4 | Latched display bits, four per pin |
| seg_lvl | output | 2*N_SEG | Level code per segment pin |
| com_lvl | output | 8 | Level code per common pin |
| port_en | output | N_PORT | Pin is in general-purpose output use |

## Verification
A slot counter or phase bit that goes wrong shifts which common sits at an extreme level. It also flips every on/off segment pair. Both show at the pins on the next tick. A slot index that strays past the active commons in three-common mode leaves no common selected, and the output after that clock shows it. Because the bench steps every tick through two full frames for each configuration, a timing error is caught within one slot of where it starts. A port decode error shows as a port_en pattern that is not a thermometer code, or as a port pin that toggles with the phase.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
   localparam int NCOM = 4;
   localparam int SW   = 2;

   typedef enum logic [1:0] {
      LV_GND  = 2'd0,
      LV_LOW  = 2'd1,
      LV_MID  = 2'd2,
      LV_FULL = 2'd3
   } lvl_t;

   // common pin: selected swings rail to rail, unselected sits at bias point
   function automatic lvl_t com_level(input logic sel, input logic ph, input logic half);
      if (sel)       return ph ? LV_GND : LV_FULL;
      else if (half) return LV_MID;
      else           return ph ? LV_MID : LV_LOW;
   endfunction

   // segment pin: on is opposite to the selected common, off is intermediate
   function automatic lvl_t seg_level(input logic on, input logic ph, input logic half);
      if (on)        return ph ? LV_FULL : LV_GND;
      else if (half) return LV_MID;
      else           return ph ? LV_LOW : LV_MID;
   endfunction
endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
   import lcd_drv_pkg::*;
#(
   parameter int SLOT_TICKS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          hold,
   input  logic          duty4,
   input  logic          fast,
   output logic [SW-1:0] slot,
   output logic          phase
);
   localparam int CW = $clog2(2 * SLOT_TICKS + 1);
   localparam logic [CW-1:0] LAST_FAST = CW'(SLOT_TICKS - 1);
   localparam logic [CW-1:0] LAST_SLOW = CW'(2 * SLOT_TICKS - 1);
   localparam logic [SW-1:0] TOP4 = SW'(NCOM - 1);
   localparam logic [SW-1:0] TOP3 = SW'(NCOM - 2);

   logic [CW-1:0] cnt_q;
   logic [SW-1:0] slot_q;
   logic          phase_q;
   logic          end_tick, end_slot, stray;

   always_comb begin
      end_tick = cnt_q >= (fast ? LAST_FAST : LAST_SLOW);
      end_slot = duty4 ? (slot_q == TOP4) : (slot_q >= TOP3);
      stray    = !duty4 && (slot_q == TOP4);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hold) begin
         cnt_q   <= '0;
         slot_q  <= '0;
         phase_q <= 1'b0;
      end else if (stray) begin
         slot_q  <= '0;
      end else if (tick) begin
         if (end_tick) begin
            cnt_q <= '0;
            if (end_slot) begin
               slot_q  <= '0;
               phase_q <= ~phase_q;
            end else begin
               slot_q  <= slot_q + 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign slot  = stray ? '0 : slot_q;
   assign phase = phase_q;
endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
   import lcd_drv_pkg::*;
(
   input  logic [SW-1:0]     slot,
   input  logic              phase,
   input  logic              half,
   input  logic              duty4,
   input  logic              blank,
   input  logic [NCOM-1:0]   xbits,
   output logic [2*NCOM-1:0] com
);
   for (genvar c = 0; c < NCOM; c++) begin : g_com
      logic sel;
      assign sel = (slot == SW'(c));
      if (c == NCOM - 1) begin : g_shared
         always_comb begin
            if (duty4) com[2*c +: 2] = com_level(sel, phase, half);
            else       com[2*c +: 2] = seg_level(xbits[slot] && !blank, phase, half);
         end
      end else begin : g_dedicated
         always_comb com[2*c +: 2] = com_level(sel, phase, half);
      end
   end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
   import lcd_drv_pkg::*;
#(
   parameter int N_SEG  = 12,
   parameter int N_PORT = 8
) (
   input  logic [NCOM*N_SEG-1:0] data,
   input  logic [SW-1:0]         slot,
   input  logic                  phase,
   input  logic                  half,
   input  logic                  blank,
   input  logic                  quiet,
   input  logic [3:0]            port_cnt,
   output logic [2*N_SEG-1:0]    seg,
   output logic [N_PORT-1:0]     pen
);
   localparam logic [3:0] NP = 4'(N_PORT);

   logic [3:0] cnt_sat;
   assign cnt_sat = (port_cnt > NP) ? NP : port_cnt;

   for (genvar k = 0; k < N_SEG; k++) begin : g_pin
      logic [NCOM-1:0] nib;
      lvl_t            wave;
      assign nib  = data[NCOM*k +: NCOM];
      assign wave = seg_level(nib[slot] && !blank, phase, half);
      if (k < N_PORT) begin : g_shared
         assign pen[k] = (4'(k) < cnt_sat);
         always_comb begin
            if (pen[k])     seg[2*k +: 2] = nib[0] ? LV_FULL : LV_GND;
            else if (quiet) seg[2*k +: 2] = LV_GND;
            else            seg[2*k +: 2] = wave;
         end
      end else begin : g_plain
         assign seg[2*k +: 2] = quiet ? LV_GND : wave;
      end
   end
endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
   import lcd_drv_pkg::*;
#(
   parameter int N_SEG      = 12,
   parameter int N_PORT     = 8,
   parameter int SLOT_TICKS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     duty4,
   input  logic                     half_bias,
   input  logic                     fast_frame,
   input  logic                     blank,
   input  logic                     save,
   input  logic                     inhibit_n,
   input  logic [3:0]               port_cnt,
   input  logic [NCOM*N_SEG+NCOM-1:0] seg_data,
   output logic [2*N_SEG-1:0]       seg_lvl,
   output logic [2*NCOM-1:0]        com_lvl,
   output logic [N_PORT-1:0]        port_en
);
   if (N_PORT < 1 || N_PORT > N_SEG || N_PORT > 15) begin : g_bad_port
      $error("lcd_mux_drive: N_PORT must be 1..min(N_SEG,15)");
   end
   if (SLOT_TICKS < 1) begin : g_bad_slot
      $error("lcd_mux_drive: SLOT_TICKS must be at least 1");
   end

   logic [SW-1:0]        slot;
   logic                 phase;
   logic [2*N_SEG-1:0]   seg_w;
   logic [2*NCOM-1:0]    com_w;
   logic [N_PORT-1:0]    pen_w;

   lcd_frame_timer #(.SLOT_TICKS(SLOT_TICKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .hold  (save),
      .duty4 (duty4),
      .fast  (fast_frame),
      .slot  (slot),
      .phase (phase)
   );

   lcd_com_drive u_com (
      .slot  (slot),
      .phase (phase),
      .half  (half_bias),
      .duty4 (duty4),
      .blank (blank),
      .xbits (seg_data[NCOM*N_SEG +: NCOM]),
      .com   (com_w)
   );

   lcd_seg_drive #(.N_SEG(N_SEG), .N_PORT(N_PORT)) u_seg (
      .data     (seg_data[NCOM*N_SEG-1:0]),
      .slot     (slot),
      .phase    (phase),
      .half     (half_bias),
      .blank    (blank),
      .quiet    (save),
      .port_cnt (port_cnt),
      .seg      (seg_w),
      .pen      (pen_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !inhibit_n) begin
         seg_lvl <= '0;
         com_lvl <= '0;
         port_en <= '0;
      end else begin
         seg_lvl <= seg_w;
         com_lvl <= save ? '0 : com_w;
         port_en <= pen_w;
      end
   end
endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk #(
   parameter int N_SEG  = 12,
   parameter int N_PORT = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               duty4,
   input logic               blank,
   input logic               save,
   input logic               inhibit_n,
   input logic [2*N_SEG-1:0] seg_lvl,
   input logic [7:0]         com_lvl,
   input logic [N_PORT-1:0]  port_en
);
   logic [3:0]        ext;
   logic [N_PORT-1:0] pen_inc;
   logic [N_SEG-1:0]  pen_wide;
   logic              blank_bad;
   logic              run;

   always_comb begin
      run      = inhibit_n && !save;
      pen_inc  = port_en + 1'b1;
      pen_wide = N_SEG'(port_en);
      for (int c = 0; c < 4; c++)
         ext[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
      blank_bad = 1'b0;
      for (int k = 0; k < N_SEG; k++)
         if (!pen_wide[k] && ((seg_lvl[2*k +: 2] == 2'd0) || (seg_lvl[2*k +: 2] == 2'd3)))
            blank_bad = 1'b1;
   end

   AST_INHIBIT_GROUND: assert property (@(posedge clk) disable iff (!rst_n)
      !inhibit_n |=> (seg_lvl == '0 && com_lvl == '0 && port_en == '0)); // R8

   AST_SAVE_COMMONS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit_n && save) |=> (com_lvl == '0)); // R7

   AST_PORT_THERMOMETER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pen_inc)); // R9

   AST_ONE_COMMON_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
      (run && duty4) |=> ($countones(ext) == 1)); // R3

   AST_ONE_COMMON_THREE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !duty4) |=> ($countones(ext[2:0]) == 1)); // R5

   AST_BLANK_SEGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (run && blank) |=> !blank_bad); // R6
endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.N_SEG(N_SEG), .N_PORT(N_PORT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .duty4     (duty4),
   .blank     (blank),
   .save      (save),
   .inhibit_n (inhibit_n),
   .seg_lvl   (seg_lvl),
   .com_lvl   (com_lvl),
   .port_en   (port_en)
);

// File: tb/lcd_mux_drive_tb.sv
`timescale 1ns/1ps
module lcd_mux_drive_tb_top;
   localparam int N_SEG = 12;
   localparam int N_PORT = 8;
   localparam int ST = 2;
   localparam int DW = 4 * N_SEG + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic duty4 = 1'b1, half_bias = 1'b0, fast_frame = 1'b1, blank = 1'b0;
   logic save = 1'b0, inhibit_n = 1'b1;
   logic [3:0] port_cnt = 4'd0;
   logic [DW-1:0] seg_data = '0;
   logic [2*N_SEG-1:0] seg_lvl;
   logic [7:0] com_lvl;
   logic [N_PORT-1:0] port_en;

   int vectors = 0;
   int miscompares = 0;
   int t = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lcd_mux_drive #(.N_SEG(N_SEG), .N_PORT(N_PORT), .SLOT_TICKS(ST)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .duty4(duty4), .half_bias(half_bias),
      .fast_frame(fast_frame), .blank(blank), .save(save), .inhibit_n(inhibit_n),
      .port_cnt(port_cnt), .seg_data(seg_data), .seg_lvl(seg_lvl),
      .com_lvl(com_lvl), .port_en(port_en));

   function automatic logic [1:0] lv_com(bit sel, bit ph, bit half);
      if (sel) return ph ? 2'd0 : 2'd3;
      if (half) return 2'd2;
      return ph ? 2'd2 : 2'd1;
   endfunction

   function automatic logic [1:0] lv_seg(bit on, bit ph, bit half);
      if (on) return ph ? 2'd3 : 2'd0;
      if (half) return 2'd2;
      return ph ? 2'd1 : 2'd2;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h (t=%0d)", tag, act, exp, t);
      end
   endtask

   task automatic check_all();
      int d = duty4 ? 4 : 3;
      int len = ST * (fast_frame ? 1 : 2);
      int q = (t / len) % (2 * d);
      bit ph = (q >= d);
      int s = q % d;
      int np = (int'(port_cnt) > N_PORT) ? N_PORT : int'(port_cnt);
      logic [2*N_SEG-1:0] es = '0;
      logic [7:0] ec = '0;
      logic [N_PORT-1:0] ep = '0;
      string tc, ts, tx;
      for (int k = 0; k < N_SEG; k++) begin
         logic [1:0] lv = lv_seg(seg_data[4*k+s] && !blank, ph, half_bias);
         if (save) lv = 2'd0;
         if (k < np) begin
            ep[k] = 1'b1;
            lv = seg_data[4*k] ? 2'd3 : 2'd0;
         end
         es[2*k +: 2] = lv;
      end
      for (int c = 0; c < 4; c++) begin
         logic [1:0] lv;
         if (c == 3 && !duty4) lv = lv_seg(seg_data[4*N_SEG+s] && !blank, ph, half_bias);
         else lv = lv_com(s == c, ph, half_bias);
         ec[2*c +: 2] = save ? 2'd0 : lv;
      end
      if (!inhibit_n) begin es = '0; ec = '0; ep = '0; end
      tc = !inhibit_n ? "R8" : save ? "R7" : "R2/R3";
      ts = !inhibit_n ? "R8" : save ? "R7" : blank ? "R6/R4" : "R4";
      tx = !inhibit_n ? "R8" : save ? "R7" : duty4 ? "R3" : "R5";
      chk({tc, " commons 0..2"}, 64'(com_lvl[5:0]), 64'(ec[5:0]));
      chk({tx, " fourth common pin"}, 64'(com_lvl[7:6]), 64'(ec[7:6]));
      chk({ts, " segment pins"}, 64'(seg_lvl[2*N_SEG-1:2*N_PORT]), 64'(es[2*N_SEG-1:2*N_PORT]));
      chk(!inhibit_n ? "R8 ports" : "R9 ports", 64'({port_en, seg_lvl[2*N_PORT-1:0]}),
          64'({ep, es[2*N_PORT-1:0]}));
   endtask

   task automatic step();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      t++;
      check_all();
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   task automatic restart();
      @(negedge clk); save = 1'b1;
      settle();
      check_all();
      @(negedge clk); save = 1'b0; t = 0;
      settle();
      check_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, sampled with reset held and inputs active
      seg_data = {DW{1'b1}};
      port_cnt = 4'd5;
      @(negedge clk);
      chk("R1 segments in reset", 64'(seg_lvl), 64'd0);
      chk("R1 commons in reset", 64'(com_lvl), 64'd0);
      chk("R1 ports in reset", 64'(port_en), 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // sweep every combination of duty, bias, frame rate, blanking; port count follows
      for (int cfg = 0; cfg < 16; cfg++) begin
         logic [63:0] pat = {32'(32'h9E3779B9 * (cfg + 3)), 32'(32'h85EBCA6B ^ (cfg * 32'h01010101))};
         @(negedge clk);
         duty4 = cfg[0]; half_bias = cfg[1]; fast_frame = cfg[2]; blank = cfg[3];
         port_cnt = 4'(cfg);
         seg_data = pat[DW-1:0];
         restart();
         for (int n = 0; n < 2 * (duty4 ? 4 : 3) * ST * (fast_frame ? 1 : 2) * 2 + 1; n++)
            step();
      end

      // R7: power saving in mid frame, ticks ignored while held, restart on release
      @(negedge clk);
      duty4 = 1'b1; half_bias = 1'b0; fast_frame = 1'b1; blank = 1'b0; port_cnt = 4'd3;
      seg_data = 52'hF_0F3C_A596_6A5C;
      restart();
      for (int n = 0; n < 5; n++) step();
      @(negedge clk); save = 1'b1;
      settle();
      check_all();
      for (int n = 0; n < 3; n++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         @(negedge clk); check_all();
      end
      @(negedge clk); save = 1'b0; t = 0;
      settle();
      check_all();
      for (int n = 0; n < 4; n++) step();

      // R8: inhibit grounds everything while timing keeps counting
      @(negedge clk); inhibit_n = 1'b0;
      settle();
      check_all();
      for (int n = 0; n < 3; n++) step();
      @(negedge clk); inhibit_n = 1'b1;
      settle();
      check_all();
      for (int n = 0; n < 6; n++) step();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule